// File: doc/BRIEF.md
# Received Special Character Detector

This block watches the stream of characters coming out of a serial receiver and compares each one against a programmed match value. When a character equals that value, and both the enhanced feature set and the detection function are switched on, a sticky status flag is raised. The flag stays set until software reads the status register that holds it. While the flag is set and its interrupt enable is on, an interrupt request is raised.

Detection never removes anything from the data stream. Every received character, together with its parity and framing error bits, is forwarded one cycle later to the receive holding path, whether it matched or not. A match is accepted even when the character carries a parity or framing error. Arbitration of this interrupt against other interrupt sources happens elsewhere.

Top module: `rx_special_detect`

## Requirements
- R1: After reset, `match_flag`, `irq` and `hold_wr` are all 0.
- R2: When `rx_valid` is 1, `enh_en` is 1, `det_en` is 1 and `rx_data` equals `match_val` at a clock edge, `match_flag` is 1 after that edge.
- R3: A character sets no flag when `enh_en` or `det_en` is 0, when `rx_valid` is 0, or when `rx_data` differs from `match_val`. In these cases `match_flag` stays 0 if it was 0.
- R4: The values of `rx_perr` and `rx_ferr` have no effect on whether a match sets `match_flag`.
- R5: When `stat_rd` is 1 at a clock edge and no match occurs at that edge, `match_flag` is 0 after the edge.
- R6: When a match and `stat_rd` occur at the same clock edge, `match_flag` is 1 after the edge, so the new event is kept.
- R7: Once set, `match_flag` holds its value until a status read clears it. Clearing `enh_en` or `det_en` does not clear it.
- R8: `irq` equals `match_flag` AND `irq_en` AND `enh_en`, with no extra cycle of delay. It drops as soon as any of the three goes low.
- R9: At every clock edge, `hold_wr`, `hold_data`, `hold_perr` and `hold_ferr` take the values of `rx_valid`, `rx_data`, `rx_perr` and `rx_ferr` from that edge. This holds whether or not the character matched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | DATA_W | Received character |
| rx_perr | input | 1 | Parity error of the received character |
| rx_ferr | input | 1 | Framing error of the received character |
| match_val | input | DATA_W | Programmed special-character value |
| enh_en | input | 1 | Enhanced feature set enable |
| det_en | input | 1 | Special-character detection enable |
| irq_en | input | 1 | Interrupt enable for this source |
| stat_rd | input | 1 | Strobe: status register is being read |
| match_flag | output | 1 | Sticky special-character-seen flag |
| irq | output | 1 | Interrupt request |
| hold_wr | output | 1 | Write strobe to the receive holding path |
| hold_data | output | DATA_W | Character forwarded to the holding path |
| hold_perr | output | 1 | Forwarded parity error |
| hold_ferr | output | 1 | Forwarded framing error |

## Verification
The bench builds the block with `DATA_W` = 4. With that width it can apply all 256 pairs of character and match value under each of the four combinations of the two enables, and each pair again under all four combinations of the error bits. That sweep covers every way a compare can succeed or fail, together with the forwarding path and the interrupt gating. Directed sequences then cover a match that lands on the same edge as a status read, and a flag that must persist after detection is disabled.

// File: rtl/rx_special_detect.sv
module rx_special_detect #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_perr,
  input  logic              rx_ferr,
  input  logic [DATA_W-1:0] match_val,
  input  logic              enh_en,
  input  logic              det_en,
  input  logic              irq_en,
  input  logic              stat_rd,
  output logic              match_flag,
  output logic              irq,
  output logic              hold_wr,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_perr,
  output logic              hold_ferr
);

  logic hit;

  // error bits deliberately excluded from the compare
  assign hit = rx_valid & enh_en & det_en & (rx_data == match_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_flag <= 1'b0;
    else        match_flag <= hit | (match_flag & ~stat_rd);
  end

  assign irq = match_flag & irq_en & enh_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_wr   <= 1'b0;
      hold_data <= '0;
      hold_perr <= 1'b0;
      hold_ferr <= 1'b0;
    end else begin
      hold_wr   <= rx_valid;
      hold_data <= rx_data;
      hold_perr <= rx_perr;
      hold_ferr <= rx_ferr;
    end
  end

endmodule

// File: rtl/rx_special_detect_chk.sv
module rx_special_detect_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_perr,
  input logic              rx_ferr,
  input logic [DATA_W-1:0] match_val,
  input logic              enh_en,
  input logic              det_en,
  input logic              irq_en,
  input logic              stat_rd,
  input logic              match_flag,
  input logic              irq,
  input logic              hold_wr,
  input logic [DATA_W-1:0] hold_data,
  input logic              hold_perr,
  input logic              hold_ferr
);

  AST_SET_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && enh_en && det_en && rx_data == match_val) |=> match_flag); // R2

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!match_flag && !(rx_valid && enh_en && det_en && rx_data == match_val)) |=> !match_flag); // R3

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !(rx_valid && enh_en && det_en && rx_data == match_val)) |=> !match_flag); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flag && !stat_rd) |=> match_flag); // R7

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (match_flag && irq_en && enh_en)); // R8

  AST_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> (hold_wr && hold_data == $past(rx_data)
                  && hold_perr == $past(rx_perr) && hold_ferr == $past(rx_ferr))); // R9

endmodule

bind rx_special_detect rx_special_detect_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_rx_special_detect.sv
`timescale 1ns/1ps
module tb_rx_special_detect;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0, rx_perr = 1'b0, rx_ferr = 1'b0;
  logic [W-1:0] rx_data = '0, match_val = '0;
  logic enh_en = 1'b0, det_en = 1'b0, irq_en = 1'b0, stat_rd = 1'b0;
  logic match_flag, irq, hold_wr, hold_perr, hold_ferr;
  logic [W-1:0] hold_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rx_special_detect #(.DATA_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .match_val(match_val),
    .enh_en(enh_en), .det_en(det_en), .irq_en(irq_en), .stat_rd(stat_rd),
    .match_flag(match_flag), .irq(irq), .hold_wr(hold_wr),
    .hold_data(hold_data), .hold_perr(hold_perr), .hold_ferr(hold_ferr));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    enh_en = 1'b1; irq_en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 flag after reset", match_flag, 0);
    chk("R1 irq after reset", irq, 0);
    chk("R1 hold_wr after reset", hold_wr, 0);
    rst_n = 1'b1;
    irq_en = 1'b0;
    step();

    // exhaustive sweep: enables x data x match value x error bits
    for (int en = 0; en < 4; en++) begin
      for (int d = 0; d < 16; d++) begin
        for (int s = 0; s < 16; s++) begin
          for (int e = 0; e < 4; e++) begin
            bit exp_hit;
            string tag;
            exp_hit = (en == 3) && (d == s);
            tag = exp_hit ? ((e != 0) ? "R4 match with error" : "R2 match sets flag")
                          : "R3 no match";
            rx_data = d[W-1:0]; match_val = s[W-1:0];
            enh_en = en[1]; det_en = en[0];
            rx_perr = e[0]; rx_ferr = e[1];
            rx_valid = 1'b1; stat_rd = 1'b0; irq_en = 1'b0;
            step();
            chk(tag, match_flag, int'(exp_hit));
            chk("R9 hold_wr", hold_wr, 1);
            chk("R9 hold_data", hold_data, d);
            chk("R9 hold errors", {hold_ferr, hold_perr}, e);
            chk("R8 irq with enable off", irq, 0);
            irq_en = 1'b1;
            #1;
            chk("R8 irq with enable on", irq, int'(exp_hit && en[1]));
            rx_valid = 1'b0; stat_rd = 1'b1; irq_en = 1'b0;
            step();
            chk("R5 read clears flag", match_flag, 0);
            chk("R9 no write when idle", hold_wr, 0);
            stat_rd = 1'b0;
          end
        end
      end
    end

    // read coinciding with a match, flag already set
    enh_en = 1'b1; det_en = 1'b1; rx_data = 4'hA; match_val = 4'hA;
    rx_perr = 1'b0; rx_ferr = 1'b0; rx_valid = 1'b1;
    step();
    chk("R2 flag set", match_flag, 1);
    stat_rd = 1'b1;
    step();
    chk("R6 read plus match keeps flag", match_flag, 1);
    rx_valid = 1'b0;
    step();
    chk("R5 plain read clears", match_flag, 0);
    // read coinciding with a match, flag clear
    rx_valid = 1'b1;
    step();
    chk("R6 read plus match on clear flag", match_flag, 1);
    rx_valid = 1'b0; stat_rd = 1'b0;

    // stickiness after disabling detection and enhanced mode
    enh_en = 1'b0; det_en = 1'b0;
    rx_valid = 1'b1; rx_data = 4'h3;
    repeat (5) step();
    rx_valid = 1'b0;
    chk("R7 flag kept after disable", match_flag, 1);
    irq_en = 1'b1; #1;
    chk("R8 irq gated by enhanced mode", irq, 0);
    enh_en = 1'b1; #1;
    chk("R8 irq follows flag", irq, 1);
    irq_en = 1'b0; #1;
    chk("R8 irq drops with enable", irq, 0);
    step();
    chk("R7 flag still held", match_flag, 1);
    stat_rd = 1'b1;
    step();
    stat_rd = 1'b0;
    irq_en = 1'b1; #1;
    chk("R5 cleared after read", match_flag, 0);
    chk("R8 irq drops with flag", irq, 0);

    finish_run();
  end
endmodule